// File: doc/BRIEF.md
# Scan Decimation Stream Filter

This filter sits on a sample stream after an acquisition buffer. The stream carries scans of several channels back to back at one fast, fixed pacer rate. The filter forwards the first scan of every group of consecutive scans and throws away the scans that follow it. A fast conversion clock therefore yields a slower effective scan rate without a second timer. The group, here called a chunk, is `scan_len × (1 + skip_cnt)` samples long. The first `scan_len` samples of each chunk go to the output and the rest are swallowed. The position inside the chunk survives any gap in the input and any stall at the output, so bursts may break the stream at any point.

Configuration is taken from the `cfg_*` inputs only while `clear` is high. Software pulses `clear` at the start of every acquisition. The pulse restarts the chunk position and empties the single output register. Forwarded samples pass through that register, which obeys valid/ready. Discarded samples are accepted at once, whatever the state of `out_ready`. Sample words are never altered.

The controller has two states. In KEEP it passes samples on. In DROP it swallows them. Three transitions change the state:
- KEEP_TO_DROP: the last channel of the forwarded scan is accepted while skipping is configured.
- DROP_TO_KEEP: the last channel of the final skipped scan is accepted.
- CLEAR_TO_KEEP: `clear` is asserted, from either state.

Reset also enters KEEP.

Top module: `scan_decim_filter`

## Requirements
- R1: With active scan length L and skip count S, the filter forwards the samples accepted at chunk positions 0 to L-1 and discards those at positions L to L·(S+1)-1. The position returns to 0 after position L·(S+1)-1 and the pattern repeats.
- R2: When S is 0, every accepted sample is forwarded with its data unchanged and in its original order.
- R3: The chunk position advances only on accepted samples. Pauses in `in_valid` and stalls on `out_ready` do not shift which samples are kept.
- R4: A one-cycle `clear` restarts the chunk at position 0 and empties the output register, so `out_valid` is 0 in the cycle after it. `in_ready` is 0 while `clear` is high.
- R5: `cfg_scan_len` and `cfg_skip_cnt` are captured only while `clear` is high. Changing them at any other time has no effect until the next clear. From reset until the first clear, the filter behaves as L=1, S=0.
- R6: A sample at a discarded position is accepted (`in_ready` high) even while the output register is full and `out_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. A sample at a forwarded position is not accepted while the register is full and not draining.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: L from 1 to 16 and S from 0 to 65535 are supported. A `cfg_scan_len` of 0 acts as 1, and a value above 16 acts as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart; captures configuration |
| cfg_scan_len | input | 5 | Channels per scan (L) |
| cfg_skip_cnt | input | 16 | Scans skipped after each kept scan (S) |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample word |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample word |
| out_ready | input | 1 | Downstream accepts the output sample |

## Verification
The main function is exercised with several configurations:
- L=4, S=0 separates pass-through from filtering.
- L=3, S=2 and L=1, S=3 check chunk lengths that a fixed-size counter would get wrong.
- L=16, S=1 covers the widest scan.

Each run is paired with irregular input gaps and output stalls, so a counter that advanced on cycles rather than on accepted beats would select the wrong samples. One stream is split across two bursts with no clear between them. One configuration change is made without a clear; the next clear must then apply it. A clear placed mid-chunk shows whether the position really restarts. A stalled output with dropped samples in flight separates accept-on-drop from plain backpressure.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    typedef enum logic [0:0] {
        ST_KEEP = 1'b0,
        ST_DROP = 1'b1
    } sdf_state_e;

endpackage

// File: rtl/sdf_chunk_ctrl.sv
module sdf_chunk_ctrl
    import sdf_pkg::*;
#(
    parameter int MAX_CH = 16,
    parameter int SKIP_W = 16,
    localparam int LEN_W = $clog2(MAX_CH + 1),
    localparam int POS_W = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic              beat,
    output logic              keep
);

    sdf_state_e        state_q, state_nx;
    logic [LEN_W-1:0]  len_q;
    logic [SKIP_W-1:0] skip_q;
    logic [POS_W-1:0]  chan_pos;
    logic [SKIP_W-1:0] scan_idx;
    logic [LEN_W-1:0]  len_eff;
    logic              last_chan;
    logic              last_scan;

    // Out-of-range lengths are pinned to the nearest legal value.
    always_comb begin
        if (cfg_len == '0)
            len_eff = LEN_W'(1);
        else if (cfg_len > LEN_W'(MAX_CH))
            len_eff = LEN_W'(MAX_CH);
        else
            len_eff = cfg_len;
    end

    assign last_chan = (LEN_W'(chan_pos) == len_q - LEN_W'(1));
    assign last_scan = (scan_idx == skip_q);

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_KEEP: if (last_chan && !last_scan) state_nx = ST_DROP;
            ST_DROP: if (last_chan && last_scan)  state_nx = ST_KEEP;
            default: state_nx = ST_KEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_KEEP;
        else if (clear)
            state_q <= ST_KEEP;
        else if (beat)
            state_q <= state_nx;
    end

    // Configuration capture and position counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= LEN_W'(1);
            skip_q   <= '0;
            chan_pos <= '0;
            scan_idx <= '0;
        end else if (clear) begin
            len_q    <= len_eff;
            skip_q   <= cfg_skip;
            chan_pos <= '0;
            scan_idx <= '0;
        end else if (beat) begin
            if (!last_chan) begin
                chan_pos <= chan_pos + POS_W'(1);
            end else begin
                chan_pos <= '0;
                scan_idx <= last_scan ? '0 : scan_idx + SKIP_W'(1);
            end
        end
    end

    // Output process.
    always_comb begin
        keep = (state_q == ST_KEEP);
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(chan_pos) < len_q); // R1
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_idx <= skip_q); // R1
    AST_SKIP_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_q == '0) |-> (state_q == ST_KEEP)); // R2
    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (chan_pos == '0 && scan_idx == '0 && state_q == ST_KEEP)); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ($stable(len_q) && $stable(skip_q))); // R5

endmodule

// File: rtl/sdf_out_stage.sv
module sdf_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              room,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    assign room = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (clear) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_data))); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && out_valid && !out_ready)); // R7

endmodule

// File: rtl/scan_decim_filter.sv
module scan_decim_filter #(
    parameter int DATA_W = 16,
    parameter int MAX_CH = 16,
    parameter int SKIP_W = 16,
    localparam int LEN_W = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [LEN_W-1:0]  cfg_scan_len,
    input  logic [SKIP_W-1:0] cfg_skip_cnt,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    logic keep;
    logic room;
    logic beat;
    logic load;

    assign in_ready = !clear && (!keep || room);
    assign beat     = in_valid && in_ready;
    assign load     = beat && keep;

    sdf_chunk_ctrl #(
        .MAX_CH (MAX_CH),
        .SKIP_W (SKIP_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cfg_len  (cfg_scan_len),
        .cfg_skip (cfg_skip_cnt),
        .beat     (beat),
        .keep     (keep)
    );

    sdf_out_stage #(
        .DATA_W (DATA_W)
    ) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load      (load),
        .load_data (in_data),
        .room      (room),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !beat); // R4

endmodule

// File: tb/scan_decim_filter_tb_top.sv
`timescale 1ns/1ps
module scan_decim_filter_tb_top;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear = 1'b0;
    logic [4:0]        cfg_scan_len = 5'd1;
    logic [15:0]       cfg_skip_cnt = 16'd0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    int act_l = 1;
    int act_s = 0;
    int g_idx = 0;
    int next_id = 1;
    int exp_q[$];
    int got_q[$];

    always #2 clk = ~clk;

    scan_decim_filter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .cfg_scan_len (cfg_scan_len),
        .cfg_skip_cnt (cfg_skip_cnt),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_clear(input int l, input int s);
        @(negedge clk);
        cfg_scan_len = 5'(l);
        cfg_skip_cnt = 16'(s);
        clear = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R4", "in_ready during clear", int'(in_ready), 0);
        @(negedge clk);
        clear = 1'b0;
        chk(out_valid == 1'b0, "R4", "out_valid after clear", int'(out_valid), 0);
        act_l = (l == 0) ? 1 : ((l > 16) ? 16 : l);
        act_s = s;
        g_idx = 0;
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic stream(input int n, input int gap_mod, input int bp_mod);
        int sent = 0;
        int cyc = 0;
        int idle = 0;
        while (idle < 6) begin
            @(negedge clk);
            in_valid  = (sent < n) && (gap_mod == 0 || (cyc % gap_mod) != 0);
            in_data   = DATA_W'(next_id);
            out_ready = (bp_mod == 0) || ((cyc % bp_mod) != 0);
            #1;
            if (in_valid && in_ready) begin
                if ((g_idx % (act_l * (act_s + 1))) < act_l)
                    exp_q.push_back(next_id);
                g_idx++;
                next_id++;
                sent++;
            end
            if (out_valid && out_ready)
                got_q.push_back(int'(out_data));
            if (sent >= n && !out_valid)
                idle++;
            cyc++;
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
    endtask

    task automatic compare(input string req);
        int bad = -1;
        chk(got_q.size() == exp_q.size(), req, "forwarded count",
            got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        if (bad >= 0)
            chk(1'b0, req, "sample word", got_q[bad], exp_q[bad]);
        else
            chk(1'b1, req, "sample word", 0, 0);
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_default_pass();
        stream(10, 0, 0);
        compare("R5");
    endtask

    task automatic t_no_skip();
        do_clear(4, 0);
        stream(24, 3, 4);
        compare("R2");
    endtask

    task automatic t_skip_gaps();
        do_clear(3, 2);
        stream(40, 4, 3);
        compare("R1");
        do_clear(1, 3);
        stream(30, 5, 2);
        compare("R1");
    endtask

    task automatic t_wide_scan();
        do_clear(16, 1);
        stream(70, 7, 5);
        compare("R9");
    endtask

    task automatic t_bursts();
        do_clear(2, 2);
        stream(5, 0, 0);
        stream(7, 2, 3);
        stream(11, 0, 2);
        compare("R3");
    endtask

    task automatic t_cfg_hold();
        do_clear(2, 1);
        stream(5, 0, 0);
        cfg_scan_len = 5'd5;
        cfg_skip_cnt = 16'd3;
        stream(9, 0, 0);
        compare("R5");
        do_clear(5, 3);
        stream(45, 3, 0);
        compare("R5");
    endtask

    task automatic t_clear_mid();
        do_clear(2, 1);
        stream(3, 0, 0);
        do_clear(2, 1);
        stream(6, 0, 0);
        compare("R4");
    endtask

    task automatic t_drop_no_bp();
        do_clear(1, 2);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 16'd100;
        #1;
        chk(in_ready == 1'b1, "R7", "in_ready with empty stage", int'(in_ready), 1);
        @(negedge clk);
        in_data = 16'd101;
        #1;
        chk(out_valid == 1'b1, "R7", "out_valid holding", int'(out_valid), 1);
        chk(in_ready == 1'b1, "R6", "in_ready on dropped sample", int'(in_ready), 1);
        @(negedge clk);
        in_data = 16'd102;
        #1;
        chk(in_ready == 1'b1, "R6", "in_ready on dropped sample", int'(in_ready), 1);
        @(negedge clk);
        in_data = 16'd103;
        #1;
        chk(in_ready == 1'b0, "R7", "in_ready on stalled kept sample", int'(in_ready), 0);
        @(negedge clk);
        chk(out_data == 16'd100, "R7", "out_data under stall", int'(out_data), 100);
        in_valid = 1'b0;
        do_clear(1, 0);
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_pass();
        t_no_skip();
        t_skip_gaps();
        t_wide_scan();
        t_bursts();
        t_cfg_hold();
        t_clear_mid();
        t_drop_no_bp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule